// File: doc/BRIEF.md
# Dominant Time-out Transmit Guard

This block sits between the host's transmit data line and the enable of a single-wire bus low-side driver. A low transmit level asks for a dominant bus, and a high level leaves the bus recessive. Transmission is only allowed while the device mode is Normal. A transmit line that stays low could hold the bus dominant forever. To prevent this, the guard counts consecutive low samples. Once the count reaches a time-out, it latches a lockout that forces the driver recessive.

The lockout does not end on the first high sample. It ends only after the transmit line has been sampled high for a minimum number of consecutive cycles. A status flag shows that the lockout is active. Leaving Normal mode clears the lockout and both run counters. Both periods are parameters given in clock cycles. The defaults fit a 200 MHz clock: 6 ms for the time-out and 10 µs for the release.

Top module: `tx_dom_guard`

## Requirements
- R1: `mode_i` encodes 0 = fail-safe, 1 = Normal, 2 = silent and 3 = sleep. When `mode_i` is not 1, `drv_dom_o` is 0 whatever the level of `txd_i`.
- R2: In Normal mode with no lockout, `drv_dom_o` equals the inverse of `txd_i` in the same cycle, with no register in the path.
- R3: When `txd_i` is sampled low in Normal mode on TIMEOUT_CYC consecutive clock edges, the lockout sets on the last of those edges. From then on `drv_dom_o` is 0 and `timeout_o` is 1.
- R4: A low run of TIMEOUT_CYC-1 samples followed by a high sample does not set the lockout.
- R5: Any high sample before the time-out restarts the low count from zero. A following low run therefore again drives dominant for a full TIMEOUT_CYC cycles.
- R6: While the lockout is active, `drv_dom_o` stays 0 and `timeout_o` stays 1, even with `txd_i` low.
- R7: The lockout clears on the edge that completes RELEASE_CYC consecutive high samples of `txd_i`. A low sample before that point keeps the lockout and restarts the high count.
- R8: A clock edge that samples `mode_i` not equal to 1 clears the lockout and both counters. Low samples taken outside Normal mode do not count toward the time-out.
- R9: After reset, the lockout is clear and both counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| txd_i | input | 1 | Host transmit level (0 requests dominant) |
| mode_i | input | 2 | Device mode (1 = Normal) |
| drv_dom_o | output | 1 | Driver enable; 1 pulls the bus dominant |
| timeout_o | output | 1 | Lockout active flag |

## Verification
The hardest state to reach from the ports is a lockout with a partly filled release count. Here a stray low sample must reset the high count without ending the lockout. The stimulus first holds the transmit line low until the lockout sets. It then raises the line for exactly one sample fewer than the release period, drops it for one cycle, and then counts a full release run. A second delicate point is a low run one sample short of the time-out that is ended by a single high sample. Both threshold sides are checked with small parameter values, so each edge lands on a known cycle.

// File: rtl/tx_dom_guard_pkg.sv
package tx_dom_guard_pkg;
  typedef enum logic [1:0] {
    MODE_FAILSAFE = 2'd0,
    MODE_NORMAL   = 2'd1,
    MODE_SILENT   = 2'd2,
    MODE_SLEEP    = 2'd3
  } guard_mode_e;
endpackage

// File: rtl/tx_run_counter.sv
// Saturating run-length counter; hit_o flags the edge that completes LIMIT samples.
module tx_run_counter #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic hit_o
);
  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clr_i)                    cnt_q <= '0;
    else if (inc_i && cnt_q != LAST)   cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = inc_i && (cnt_q == LAST);

  a_r9_count_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/tx_lock_ctrl.sv
module tx_lock_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic normal_i,
  input  logic set_i,
  input  logic rel_i,
  output logic lock_o
);
  logic lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        lock_q <= 1'b0;
    else if (!normal_i) lock_q <= 1'b0;
    else if (set_i)     lock_q <= 1'b1;
    else if (rel_i)     lock_q <= 1'b0;
  end

  assign lock_o = lock_q;

  // set comes only from the low-run counter, release only from the high-run counter
  a_r7_set_rel_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(set_i && rel_i));
endmodule

// File: rtl/tx_dom_guard.sv
module tx_dom_guard
  import tx_dom_guard_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 1_200_000,
  parameter int unsigned RELEASE_CYC = 2_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       txd_i,
  input  logic [1:0] mode_i,
  output logic       drv_dom_o,
  output logic       timeout_o
);
  logic normal, lock, set_lock, rel_lock;

  assign normal = (mode_i == MODE_NORMAL);

  // low-run counter: only counts while transmitting is allowed
  tx_run_counter #(.LIMIT(TIMEOUT_CYC)) u_dom_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (!normal || txd_i || lock),
    .inc_i (normal && !txd_i && !lock),
    .hit_o (set_lock)
  );

  // high-run counter: only counts during lockout
  tx_run_counter #(.LIMIT(RELEASE_CYC)) u_rel_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (!normal || !txd_i || !lock),
    .inc_i (normal && txd_i && lock),
    .hit_o (rel_lock)
  );

  tx_lock_ctrl u_lock (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .normal_i(normal),
    .set_i   (set_lock),
    .rel_i   (rel_lock),
    .lock_o  (lock)
  );

  assign drv_dom_o = normal && !txd_i && !lock;
  assign timeout_o = lock;

  a_r1_quiet_outside_normal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != MODE_NORMAL) |-> !drv_dom_o);
  a_r6_locked_recessive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> !drv_dom_o);
  a_r3_lock_after_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> $past(!txd_i && mode_i == MODE_NORMAL));
  a_r7_release_after_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(timeout_o) |-> $past(txd_i || mode_i != MODE_NORMAL));
  a_r8_exit_clears_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != MODE_NORMAL) |=> !timeout_o);
endmodule

// File: tb/tx_dom_guard_tb.sv
`timescale 1ns/1ps
module tx_dom_guard_tb;
  localparam int unsigned T = 20;
  localparam int unsigned R = 8;
  localparam logic [1:0] M_FS = 2'd0, M_NORM = 2'd1, M_SIL = 2'd2, M_SLP = 2'd3;

  logic clk = 1'b0, rst_ni = 1'b0, txd = 1'b1;
  logic [1:0] mode = M_NORM;
  logic drv, tout;

  typedef struct { logic drv; logic tout; string tag; } exp_t;
  exp_t exp_q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tx_dom_guard #(.TIMEOUT_CYC(T), .RELEASE_CYC(R)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .txd_i(txd), .mode_i(mode),
    .drv_dom_o(drv), .timeout_o(tout)
  );

  // driver: apply inputs at negedge, push expected outputs for this cycle
  task automatic step(input logic t, input logic [1:0] m,
                      input logic e_drv, input logic e_to, input string tag);
    exp_t e;
    @(negedge clk);
    txd = t; mode = m;
    e.drv = e_drv; e.tout = e_to; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: compare shortly after inputs settle, well before the next posedge
  initial forever begin
    @(negedge clk);
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_chk++;
      if (drv !== e.drv || tout !== e.tout) begin
        n_fail++;
        $display("FAIL %s: drv=%b to=%b expected drv=%b to=%b at %0t",
                 e.tag, drv, tout, e.drv, e.tout, $time);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    step(1, M_NORM, 0, 0, "R9 reset state");
    // R2 pass-through
    step(0, M_NORM, 1, 0, "R2");
    step(1, M_NORM, 0, 0, "R2");
    step(0, M_NORM, 1, 0, "R2");
    step(1, M_NORM, 0, 0, "R2");
    // R4: one sample short of time-out
    for (int i = 0; i < int'(T) - 1; i++) step(0, M_NORM, 1, 0, "R4");
    step(1, M_NORM, 0, 0, "R4 no lock");
    // R5: count restarted, full run still dominant
    for (int i = 0; i < int'(T); i++) step(0, M_NORM, 1, 0, "R5");
    // R3: time-out reached
    step(0, M_NORM, 0, 1, "R3 lock");
    for (int i = 0; i < 3; i++) step(0, M_NORM, 0, 1, "R6");
    // R7: one high sample short, then low
    for (int i = 0; i < int'(R) - 1; i++) step(1, M_NORM, 0, 1, "R7 partial");
    step(0, M_NORM, 0, 1, "R7 short release");
    for (int i = 0; i < int'(R); i++) step(1, M_NORM, 0, 1, "R7 full");
    step(1, M_NORM, 0, 0, "R7 released");
    step(0, M_NORM, 1, 0, "R2 after release");
    step(1, M_NORM, 0, 0, "R2");
    // R8: lock again, then leave Normal
    for (int i = 0; i < int'(T); i++) step(0, M_NORM, 1, 0, "R3 run");
    step(0, M_NORM, 0, 1, "R3 lock");
    step(0, M_SIL, 0, 1, "R8 exit cycle");
    step(0, M_SIL, 0, 0, "R8 cleared");
    for (int i = 0; i < int'(T) + 5; i++) step(0, M_SIL, 0, 0, "R1 silent");
    step(0, M_SLP, 0, 0, "R1 sleep");
    step(0, M_FS, 0, 0, "R1 failsafe");
    for (int i = 0; i < int'(T); i++) step(0, M_NORM, 1, 0, "R8 fresh count");
    step(0, M_NORM, 0, 1, "R3 lock");
    step(1, M_FS, 0, 1, "R8 exit cycle");
    step(0, M_NORM, 1, 0, "R8 released by exit");
    step(1, M_NORM, 0, 0, "R2");
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule